// File: doc/BRIEF.md
# Multiplexed Four-Digit Seven-Segment Controller

This block drives a four-digit, common-anode seven-segment display by time multiplexing. The four digits share one set of seven cathode lines, and each digit has its own anode enable. Software loads four 4-bit values through two byte-wide write-only registers on a simple register bus. The block then lights one digit at a time and puts that digit's decoded segment pattern on the shared cathodes. The values are decoded as hexadecimal.

The scan advances one digit on each rising edge of a slow display clock (256 Hz to 1 kHz), with no internal prescaler. That gives a full four-digit refresh period between roughly 4 ms and 16 ms. The display clock is brought into the system clock domain before use. Each step updates the anode and cathode registers together on the same system clock edge, so a digit is never lit with another digit's pattern. A register write changes nothing on the pins until the next scan step.

Top module: `seg_mux_ctrl`

## Requirements
- R1: At most one bit of `anode_o` is high at any time (active high). After the first scan step following reset, exactly one bit is high.
- R2: `cathode_o` is active low: a segment is lit when its bit is 0. Bit 6 is segment a, bit 5 is b, and so on down to bit 0, which is g. Lit patterns for a..g are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R3: Nibble values 10 to 15 show A, b, C, d, E and F, with lit patterns for a..g of 1110111, 0011111, 1001110, 0111101, 1001111 and 1000111.
- R4: Each rising edge of `disp_clk_i` advances the scan by one digit. `anode_o` bit 0 is digit 1 and bit 3 is digit 4. The first step after reset lights digit 1, and the order is digit 1, 2, 3, 4, then back to 1.
- R5: While `rst_i` is high, and in the cycle after it, `anode_o` is 0 and `cathode_o` is all ones. Reset clears both registers and returns the scan to digit 1.
- R6: A write with `wr_en_i` high to address 6 stores digit 1 in data bits 3:0 and digit 2 in bits 7:4. A write to address 7 stores digit 3 in bits 3:0 and digit 4 in bits 7:4. Writes to any other address, or with `wr_en_i` low, change nothing.
- R7: Outputs change only at a scan step. A register write shows on the pins only when its digit is next scanned, and a step reaches the pins within four system clock cycles of the display clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| disp_clk_i | input | 1 | Slow display clock, asynchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| anode_o | output | 4 | Active-high digit enables, bit 0 = digit 1 |
| cathode_o | output | 7 | Active-low segments, bit 6 = a ... bit 0 = g |

## Verification
A scan index that is wrong or skips a value shows as the wrong anode bit, or as a gap in the rotation, on the very next display clock step. A mis-decoded register address or a swapped nibble shows as the wrong cathode pattern when the affected digit is next scanned, which is at most four steps later. A broken update gate would let a write change the cathodes between steps. The bench catches this by sampling before the next display edge.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W = 7;

  // Lit-segment pattern, bit 6 = a ... bit 0 = g.
  function automatic logic [SEG_W-1:0] hex_to_lit(input logic [3:0] v);
    logic [SEG_W-1:0] p;
    case (v)
      4'h0: p = 7'b1111110;
      4'h1: p = 7'b0110000;
      4'h2: p = 7'b1101101;
      4'h3: p = 7'b1111001;
      4'h4: p = 7'b0110011;
      4'h5: p = 7'b1011011;
      4'h6: p = 7'b1011111;
      4'h7: p = 7'b1110000;
      4'h8: p = 7'b1111111;
      4'h9: p = 7'b1111011;
      4'hA: p = 7'b1110111;
      4'hB: p = 7'b0011111;
      4'hC: p = 7'b1001110;
      4'hD: p = 7'b0111101;
      4'hE: p = 7'b1001111;
      default: p = 7'b1000111;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/seg_step_sync.sv
module seg_step_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/seg_nibble_regs.sv
module seg_nibble_regs #(
  parameter int NUM_DIGITS = 4,
  parameter int NIBBLE_W   = 4,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int BASE_ADDR  = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NUM_DIGITS*NIBBLE_W-1:0] values_o
);
  localparam int TOTAL_W  = NUM_DIGITS * NIBBLE_W;
  localparam int NUM_REGS = TOTAL_W / DATA_W;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i) begin
      if (rst_i)
        values_o[r*DATA_W +: DATA_W] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(BASE_ADDR + r))
        values_o[r*DATA_W +: DATA_W] <= wr_data_i;
    end
  end
endmodule

// File: rtl/seg_scan.sv
module seg_scan #(
  parameter int NUM_DIGITS = 4,
  parameter int NIBBLE_W   = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic                           step_i,
  input  logic [NUM_DIGITS*NIBBLE_W-1:0] values_i,
  output logic [NUM_DIGITS-1:0]          anode_o,
  output logic [seg_pkg::SEG_W-1:0]      cathode_o
);
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic [IDX_W-1:0]    idx_q;
  logic [NIBBLE_W-1:0] cur_nib;

  assign cur_nib = values_i[idx_q*NIBBLE_W +: NIBBLE_W];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      idx_q     <= '0;
      anode_o   <= '0;
      cathode_o <= '1;
    end else if (step_i) begin
      anode_o   <= NUM_DIGITS'(1) << idx_q;
      cathode_o <= ~seg_pkg::hex_to_lit(cur_nib[3:0]);
      idx_q     <= (idx_q == IDX_W'(NUM_DIGITS - 1)) ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/seg_mux_ctrl.sv
module seg_mux_ctrl #(
  parameter int NUM_DIGITS  = 4,
  parameter int NIBBLE_W    = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int BASE_ADDR   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      disp_clk_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  output logic [NUM_DIGITS-1:0]     anode_o,
  output logic [seg_pkg::SEG_W-1:0] cathode_o
);
  logic                           step_pulse;
  logic [NUM_DIGITS*NIBBLE_W-1:0] digit_vals;

  seg_step_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(disp_clk_i), .rise_o(step_pulse)
  );

  seg_nibble_regs #(
    .NUM_DIGITS(NUM_DIGITS), .NIBBLE_W(NIBBLE_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .values_o(digit_vals)
  );

  seg_scan #(.NUM_DIGITS(NUM_DIGITS), .NIBBLE_W(NIBBLE_W)) u_scan (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(step_pulse), .values_i(digit_vals),
    .anode_o(anode_o), .cathode_o(cathode_o)
  );
endmodule

// File: rtl/seg_mux_ctrl_checker.sv
module seg_mux_ctrl_checker #(
  parameter int NUM_DIGITS = 4
) (
  input logic                      clk_i,
  input logic                      rst_i,
  input logic                      step,
  input logic [NUM_DIGITS-1:0]     anode_o,
  input logic [seg_pkg::SEG_W-1:0] cathode_o
);
  // R1: never more than one digit enabled
  a_r1_single_anode: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(anode_o));

  // R1: once a digit is lit, some digit stays lit
  a_r1_stays_lit: assert property (@(posedge clk_i) disable iff (rst_i)
    (anode_o != '0) |=> (anode_o != '0));

  // R4: a step from a lit digit rotates to the next one
  a_r4_rotate: assert property (@(posedge clk_i) disable iff (rst_i)
    (step && anode_o != '0) |=>
      (anode_o == {$past(anode_o[NUM_DIGITS-2:0]), $past(anode_o[NUM_DIGITS-1])}));

  // R4: the first step from the dark state lights digit 1
  a_r4_first_digit: assert property (@(posedge clk_i) disable iff (rst_i)
    (step && anode_o == '0) |=> (anode_o == NUM_DIGITS'(1)));

  // R5: reset blanks the display
  a_r5_reset_blank: assert property (@(posedge clk_i)
    rst_i |=> (anode_o == '0 && cathode_o == '1));

  // R7: outputs hold between steps
  a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !step |=> ($stable(anode_o) && $stable(cathode_o)));
endmodule

bind seg_mux_ctrl seg_mux_ctrl_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .step(step_pulse),
  .anode_o(anode_o), .cathode_o(cathode_o)
);

// File: tb/seg_mux_ctrl_bench.sv
module seg_mux_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disp_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] anode;
  logic [6:0] cathode;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seg_mux_ctrl u_seg_mux_ctrl (
    .clk_i(clk), .rst_i(rst), .disp_clk_i(disp_clk), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .anode_o(anode), .cathode_o(cathode)
  );

  function automatic logic [6:0] lit(input logic [3:0] v);
    case (v)
      4'd0: return 7'b1111110;  4'd1: return 7'b0110000;
      4'd2: return 7'b1101101;  4'd3: return 7'b1111001;
      4'd4: return 7'b0110011;  4'd5: return 7'b1011011;
      4'd6: return 7'b1011111;  4'd7: return 7'b1110000;
      4'd8: return 7'b1111111;  4'd9: return 7'b1111011;
      4'd10: return 7'b1110111; 4'd11: return 7'b0011111;
      4'd12: return 7'b1001110; 4'd13: return 7'b0111101;
      4'd14: return 7'b1001111; default: return 7'b1000111;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] exp_an, input logic [6:0] exp_ca);
    checks++;
    if (anode !== exp_an || cathode !== exp_ca) begin
      errors++;
      $display("FAIL %s: anode=%b cathode=%b expected anode=%b cathode=%b",
               req, anode, cathode, exp_an, exp_ca);
    end
  endtask

  task automatic bus_write(input logic en, input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic step();
    disp_clk = 1'b1;
    repeat (4) @(posedge clk);
    #2 disp_clk = 1'b0;
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;
  endtask

  // Scan all four digits from digit 1 and compare with expected nibbles.
  task automatic scan4(input string req, input logic [15:0] vals);
    for (int i = 0; i < 4; i++) begin
      step();
      check(req, 4'(1 << i), ~lit(vals[i*4 +: 4]));
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R5 reset blank", 4'b0000, 7'b1111111);
    step();
    check("R5 cleared value on digit 1", 4'b0001, ~lit(4'd0));
    repeat (3) step();
  endtask

  task automatic t_decimal();
    bus_write(1'b1, 4'd6, 8'h21);
    bus_write(1'b1, 4'd7, 8'h43);
    scan4("R2 R6 digits 1..4", 16'h4321);
    step();
    check("R4 wrap to digit 1", 4'b0001, ~lit(4'd1));
    repeat (3) step();
    bus_write(1'b1, 4'd6, 8'h65);
    bus_write(1'b1, 4'd7, 8'h87);
    scan4("R2 decode 5..8", 16'h8765);
    bus_write(1'b1, 4'd6, 8'h09);
    bus_write(1'b1, 4'd7, 8'h00);
    scan4("R2 decode 9,0", 16'h0009);
  endtask

  task automatic t_hex();
    bus_write(1'b1, 4'd6, 8'hBA);
    bus_write(1'b1, 4'd7, 8'hDC);
    scan4("R3 hex A-D", 16'hDCBA);
    bus_write(1'b1, 4'd6, 8'hFE);
    scan4("R3 hex E,F", 16'hDCFE);
  endtask

  task automatic t_ignored();
    bus_write(1'b1, 4'd5, 8'h11);
    bus_write(1'b1, 4'd8, 8'h22);
    bus_write(1'b0, 4'd6, 8'h33);
    bus_write(1'b1, 4'd14, 8'h44);
    scan4("R6 ignored writes", 16'hDCFE);
  endtask

  task automatic t_mid_digit();
    step();
    check("R7 digit 1 before write", 4'b0001, ~lit(4'hE));
    bus_write(1'b1, 4'd6, 8'h77);
    repeat (5) @(posedge clk);
    #2;
    check("R7 no change mid digit", 4'b0001, ~lit(4'hE));
    step();
    check("R7 new value on next digit", 4'b0010, ~lit(4'h7));
    repeat (2) step();
    step();
    check("R7 new value on digit 1", 4'b0001, ~lit(4'h7));
    repeat (3) step();
  endtask

  task automatic t_reset_mid();
    step();
    step();
    do_reset();
    check("R5 blank after mid-scan reset", 4'b0000, 7'b1111111);
    step();
    check("R4 first step lights digit 1", 4'b0001, ~lit(4'd0));
    step();
    check("R1 R4 digit 2 after reset", 4'b0010, ~lit(4'd0));
  endtask

  initial begin
    t_reset();
    t_decimal();
    t_hex();
    t_ignored();
    t_mid_digit();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule